// File: doc/BRIEF.md
# Set/Clear GPIO Controller

This block is a register-mapped general-purpose I/O controller for up to 32 pins. A processor-side bus reaches it with a word address, a write strobe with write data, and a read strobe with read data. The output data latch is never written directly. One register sets latch bits and another clears them, each acting only where the written word has a 1. Because of this, two agents can change different pins without a read-modify-write race.

A direction register drives the output enables. Its polarity is chosen at build time. Pin inputs pass through a two-stage synchronizer, and the result is readable as a word. A plain mask register hands pins to alternate peripheral functions and is brought out as a port. Each pin also has an 8-bit source selector, packed four per word. A selector of zero routes the output latch bit to the pin. Any other value routes one bit of a peripheral output vector to the pin.

Top module: `gpio_setclr_ctrl`

Register word addresses:
- 0: direction
- 1: synchronized inputs
- 2: set, which reads back as the latch
- 3: clear
- 4: function mask
- 8 to 15: selector words

## Requirements
- R1: A write to word 2 sets every latch bit where the write data is 1 and leaves every other latch bit unchanged. The latch changes only on writes to words 2 and 3.
- R2: A write to word 3 clears every latch bit where the write data is 1 and leaves every other latch bit unchanged.
- R3: A read strobe returns data on `bus_rdata_o` one clock after it is sampled. Word 2 reads the output latch, and word 3 always reads zero.
- R4: Input pins pass through two flops. `in_sync_o` shows a pin level two rising edges after it is applied, and a read of word 1 returns that synchronized value with pin n in bit n.
- R5: With `DIR_ONE_IS_OUT`=1, a direction bit of 1 enables that pin's output. With `DIR_ONE_IS_OUT`=0, a 1 makes the pin an input and a 0 enables its output. The direction register reads back as written in both variants.
- R6: Word 4 is a read/write mask. A read after a write returns the written value, and `alt_func_o` carries it.
- R7: Pin g's selector is byte g%4 of word 8+g/4, at bit offset 8*(g%4). With selector 0, `pins_o[g]` equals latch bit g. With selector k≥1, `pins_o[g]` equals `periph_i[k]`, or 0 when k≥`NUM_SRC`.
- R8: Register bits at or above `NUM_PINS` read as zero and ignore writes. Selector bytes for pins at or above `NUM_PINS` read as zero, and writes to them do not change any pin.
- R9: After reset, the latch, the function mask and all selectors are zero, and every pin is an input. The direction register then reads 0 in the default variant and all implemented ones in the inverted variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| pins_i | input | NUM_PINS | Raw pin levels |
| periph_i | input | NUM_SRC | Peripheral output vector |
| pins_o | output | NUM_PINS | Pin output values |
| oe_o | output | NUM_PINS | Pin output enables |
| alt_func_o | output | NUM_PINS | Alternate function mask |
| in_sync_o | output | NUM_PINS | Synchronized pin inputs |

## Verification
The assertions check on every cycle that:
- set and clear writes act on exactly the written bits;
- the latch and the selectors hold when not addressed;
- the clear word reads zero and the set word reads the latch;
- the synchronized inputs trail the pins by two edges.

The bench scenarios cover the rest: the selector byte layout, routing of peripheral bits including out-of-range selectors, the inverted direction variant, and the zeroed bits above the pin count. It checks these by comparing two instances with opposite direction polarity against a bench model.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned SEL_W      = 8;
   localparam int unsigned SEL_PER_WD = WORD_W / SEL_W;
   localparam int unsigned MAX_PINS   = 32;
   localparam int unsigned SRC_SPACE  = 1 << SEL_W;
   // word addresses
   localparam int unsigned A_DIR  = 0;
   localparam int unsigned A_IN   = 1;
   localparam int unsigned A_SET  = 2;
   localparam int unsigned A_CLR  = 3;
   localparam int unsigned A_FUNC = 4;
   localparam int unsigned A_SEL  = 8;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q, sync_q;
   logic [1:0]   warm_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         meta_q <= '0;
         sync_q <= '0;
         warm_q <= '0;
      end else begin
         meta_q <= d_i;
         sync_q <= meta_q;
         if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
   end

   assign q_o = sync_q;

   // two-edge input latency once both stages hold post-reset data
   assert_sync_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_sc_selbank.sv
module gpio_sc_selbank
   import gpio_setclr_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              wr_en_i,
   input  logic [2:0]                        wr_idx_i,
   input  logic [WORD_W-1:0]                 wr_data_i,
   input  logic [2:0]                        rd_idx_i,
   output logic [WORD_W-1:0]                 rd_word_o,
   output logic [NUM_PINS-1:0][SEL_W-1:0]    sel_o
);
   logic [SEL_W-1:0] sel_q [NUM_PINS];

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_sel
      localparam logic [2:0]  WD  = 3'(g / SEL_PER_WD);
      localparam int unsigned LSB = SEL_W * (g % SEL_PER_WD);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            sel_q[g] <= '0;
         else if (wr_en_i && (wr_idx_i == WD))
            sel_q[g] <= wr_data_i[LSB +: SEL_W];
      end
      assign sel_o[g] = sel_q[g];
   end

   always_comb begin
      rd_word_o = '0;
      for (int g = 0; g < NUM_PINS; g++) begin
         if (rd_idx_i == 3'(g / SEL_PER_WD))
            rd_word_o[SEL_W*(g % SEL_PER_WD) +: SEL_W] = sel_q[g];
      end
   end

   assert_sel_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(sel_o));
endmodule

// File: rtl/gpio_sc_pinmux.sv
module gpio_sc_pinmux
   import gpio_setclr_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned NUM_SRC  = 32
) (
   input  logic [NUM_PINS-1:0][SEL_W-1:0] sel_i,
   input  logic [NUM_PINS-1:0]            latch_i,
   input  logic [NUM_SRC-1:0]             periph_i,
   output logic [NUM_PINS-1:0]            pins_o
);
   localparam int unsigned PAD = SRC_SPACE - NUM_SRC;
   logic [SRC_SPACE-1:0] src_ext;

   assign src_ext = {{PAD{1'b0}}, periph_i};

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign pins_o[g] = (sel_i[g] == '0) ? latch_i[g] : src_ext[sel_i[g]];
   end
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
   import gpio_setclr_pkg::*;
#(
   parameter int unsigned NUM_PINS       = 24,
   parameter int unsigned NUM_SRC        = 32,
   parameter int unsigned ADDR_W         = 4,
   parameter bit          DIR_ONE_IS_OUT = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic [WORD_W-1:0]   bus_wdata_i,
   input  logic                bus_rd_i,
   output logic [WORD_W-1:0]   bus_rdata_o,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [NUM_SRC-1:0]  periph_i,
   output logic [NUM_PINS-1:0] pins_o,
   output logic [NUM_PINS-1:0] oe_o,
   output logic [NUM_PINS-1:0] alt_func_o,
   output logic [NUM_PINS-1:0] in_sync_o
);
   localparam logic [NUM_PINS-1:0] DIR_RST = DIR_ONE_IS_OUT ? '0 : '1;

   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..32");
   end
   if (NUM_SRC < 2 || NUM_SRC >= SRC_SPACE) begin : g_bad_src
      $error("NUM_SRC must lie in 2..255");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end

   logic [NUM_PINS-1:0] wd;
   logic [NUM_PINS-1:0] out_q, dir_q, func_q;
   logic                hit_set, hit_clr, hit_dir, hit_func, hit_sel;
   logic [WORD_W-1:0]   sel_word;
   logic [NUM_PINS-1:0][SEL_W-1:0] sel;

   assign wd       = bus_wdata_i[NUM_PINS-1:0];
   assign hit_dir  = bus_addr_i == ADDR_W'(A_DIR);
   assign hit_set  = bus_addr_i == ADDR_W'(A_SET);
   assign hit_clr  = bus_addr_i == ADDR_W'(A_CLR);
   assign hit_func = bus_addr_i == ADDR_W'(A_FUNC);
   assign hit_sel  = bus_addr_i[ADDR_W-1:3] == (ADDR_W-3)'(A_SEL >> 3);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q  <= '0;
         dir_q  <= DIR_RST;
         func_q <= '0;
      end else if (bus_wr_i) begin
         if (hit_set)  out_q  <= out_q | wd;
         if (hit_clr)  out_q  <= out_q & ~wd;
         if (hit_dir)  dir_q  <= wd;
         if (hit_func) func_q <= wd;
      end
   end

   gpio_sc_sync #(.W(NUM_PINS)) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pins_i),
      .q_o    (in_sync_o)
   );

   gpio_sc_selbank #(.NUM_PINS(NUM_PINS)) selbank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bus_wr_i && hit_sel),
      .wr_idx_i  (bus_addr_i[2:0]),
      .wr_data_i (bus_wdata_i),
      .rd_idx_i  (bus_addr_i[2:0]),
      .rd_word_o (sel_word),
      .sel_o     (sel)
   );

   gpio_sc_pinmux #(.NUM_PINS(NUM_PINS), .NUM_SRC(NUM_SRC)) pinmux_i (
      .sel_i    (sel),
      .latch_i  (out_q),
      .periph_i (periph_i),
      .pins_o   (pins_o)
   );

   if (DIR_ONE_IS_OUT) begin : g_dir_pos
      assign oe_o = dir_q;
   end else begin : g_dir_neg
      assign oe_o = ~dir_q;
   end

   assign alt_func_o = func_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bus_rdata_o <= '0;
      end else if (bus_rd_i) begin
         if (hit_dir)       bus_rdata_o <= WORD_W'(dir_q);
         else if (bus_addr_i == ADDR_W'(A_IN)) bus_rdata_o <= WORD_W'(in_sync_o);
         else if (hit_set)  bus_rdata_o <= WORD_W'(out_q);
         else if (hit_func) bus_rdata_o <= WORD_W'(func_q);
         else if (hit_sel)  bus_rdata_o <= sel_word;
         else               bus_rdata_o <= '0;
      end
   end

   assert_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && hit_set) |=> ((out_q & $past(wd)) == $past(wd)));

   assert_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && hit_clr) |=> ((out_q & $past(wd)) == '0));

   assert_latch_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_wr_i && (hit_set || hit_clr)) |=> $stable(out_q));

   assert_clr_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && hit_clr) |=> (bus_rdata_o == '0));

   assert_set_reads_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && hit_set) |=> (bus_rdata_o == WORD_W'($past(out_q))));
endmodule

// File: tb/gpio_setclr_ctrl_tb_top.sv
module gpio_setclr_ctrl_tb_top;
   localparam int unsigned NP = 24;
   localparam int unsigned NS = 32;
   localparam logic [31:0] MASK = 32'(({NP{1'b1}}));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    addr = '0;
   logic          wr = 1'b0, rd = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata_a, rdata_b;
   logic [NP-1:0] pins_in = '0;
   logic [NS-1:0] periph = '0;
   logic [NP-1:0] pins_a, pins_b, oe_a, oe_b, func_a, func_b, sync_a, sync_b;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   logic [31:0] m_out, m_dir_a, m_dir_b, m_func;
   logic [7:0]  m_sel [32];

   always #4 clk = ~clk;

   gpio_setclr_ctrl #(.NUM_PINS(NP), .NUM_SRC(NS), .ADDR_W(4), .DIR_ONE_IS_OUT(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rd_i(rd), .bus_rdata_o(rdata_a), .pins_i(pins_in), .periph_i(periph),
      .pins_o(pins_a), .oe_o(oe_a), .alt_func_o(func_a), .in_sync_o(sync_a));

   gpio_setclr_ctrl #(.NUM_PINS(NP), .NUM_SRC(NS), .ADDR_W(4), .DIR_ONE_IS_OUT(1'b0)) dut_inv_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
      .bus_rd_i(rd), .bus_rdata_o(rdata_b), .pins_i(pins_in), .periph_i(periph),
      .pins_o(pins_b), .oe_o(oe_b), .alt_func_o(func_b), .in_sync_o(sync_b));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic exp_pin(int g);
      if (m_sel[g] == 8'd0) return m_out[g];
      if (m_sel[g] < 8'(NS)) return periph[m_sel[g]];
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_pins();
      logic [31:0] v = '0;
      for (int g = 0; g < int'(NP); g++) v[g] = exp_pin(g);
      return v;
   endfunction

   function automatic logic [31:0] exp_read(int a, bit inv);
      logic [31:0] v = '0;
      case (a)
         0: return inv ? m_dir_b : m_dir_a;
         1: return 32'(sync_a);
         2: return m_out;
         3: return 32'h0;
         4: return m_func;
         default: begin
            if (a >= 8 && a < 16)
               for (int b = 0; b < 4; b++)
                  if ((a - 8) * 4 + b < int'(NP)) v[8*b +: 8] = m_sel[(a - 8) * 4 + b];
            return v;
         end
      endcase
   endfunction

   task automatic bus_wr(int a, logic [31:0] d);
      @(negedge clk);
      addr = 4'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      case (a)
         0: begin m_dir_a = d & MASK; m_dir_b = d & MASK; end
         2: m_out = m_out | (d & MASK);
         3: m_out = m_out & ~(d & MASK);
         4: m_func = d & MASK;
         default:
            if (a >= 8 && a < 16)
               for (int b = 0; b < 4; b++)
                  if ((a - 8) * 4 + b < int'(NP)) m_sel[(a - 8) * 4 + b] = d[8*b +: 8];
      endcase
   endtask

   task automatic bus_rd(int a, output logic [31:0] ra, output logic [31:0] rb);
      @(negedge clk);
      addr = 4'(a); rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      ra = rdata_a; rb = rdata_b;
   endtask

   task automatic rd_chk(string req, int a);
      logic [31:0] ra, rb;
      bus_rd(a, ra, rb);
      chk(req, ra, exp_read(a, 1'b0));
      chk(req, rb, exp_read(a, 1'b1));
   endtask

   task automatic pins_chk(string req);
      chk(req, 32'(pins_a), exp_pins());
      chk(req, 32'(pins_b), exp_pins());
      chk(req, 32'(oe_a), m_dir_a);
      chk(req, 32'(oe_b), ~m_dir_b & MASK);
      chk(req, 32'(func_a), m_func);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] ra, rb;
      void'($urandom(32'd4242));
      m_out = '0; m_dir_a = '0; m_dir_b = MASK; m_func = '0;
      for (int g = 0; g < 32; g++) m_sel[g] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state, both polarities
      pins_chk("R9");
      rd_chk("R9", 0);
      rd_chk("R9", 2);
      rd_chk("R9", 4);
      rd_chk("R9", 8);

      // R1 / R2 set and clear
      bus_wr(2, 32'h00A5_5AA5); rd_chk("R1", 2); pins_chk("R1");
      bus_wr(3, 32'h0000_00F0); rd_chk("R2", 2); pins_chk("R2");
      bus_wr(3, 32'h0); rd_chk("R2", 2);
      // R3 clear reads zero even with latch non-zero
      rd_chk("R3", 3);

      // R8 unimplemented bits
      bus_wr(2, 32'hFFFF_FFFF); rd_chk("R8", 2);
      bus_wr(0, 32'hFFFF_FFFF); rd_chk("R8", 0);
      bus_wr(15, 32'h0505_0505); rd_chk("R8", 15); pins_chk("R8");
      bus_wr(13, 32'h0302_0100); rd_chk("R8", 13);

      // R5 direction polarity
      bus_wr(0, 32'h0012_34C3); pins_chk("R5"); rd_chk("R5", 0);

      // R6 function mask
      bus_wr(4, 32'hF0F0_A55A); rd_chk("R6", 4); pins_chk("R6");

      // R7 selector layout and routing
      periph = 32'h0000_0020;
      bus_wr(3, 32'hFFFF_FFFF);
      bus_wr(8, 32'h00C8_0500); rd_chk("R7", 8); pins_chk("R7");
      periph = 32'h0000_0000; #1 pins_chk("R7");
      bus_wr(9, 32'h1F00_0001); periph = 32'h8000_0002; #1 pins_chk("R7");

      // R4 synchronizer latency and IN read
      @(negedge clk); pins_in = 24'h5A_C3_0F;
      @(negedge clk); chk("R4", 32'(sync_a), 32'h0);
      @(negedge clk); chk("R4", 32'(sync_a), 32'h005A_C30F);
      chk("R4", 32'(sync_b), 32'h005A_C30F);
      rd_chk("R4", 1);

      // randomized mix
      for (int it = 0; it < 600; it++) begin
         int op = $urandom_range(0, 9);
         logic [31:0] d = $urandom();
         periph = $urandom();
         case (op)
            0: bus_wr(0, d);
            1, 2: bus_wr(2, d);
            3, 4: bus_wr(3, d);
            5: bus_wr(4, d);
            6: bus_wr(8 + $urandom_range(0, 7), d & 32'h1F1F_1F1F);
            7: bus_wr(8 + $urandom_range(0, 7), d);
            8: begin
               pins_in = NP'($urandom());
               repeat (3) @(negedge clk);
               rd_chk("R4", 1);
            end
            default: rd_chk("R3", 3);
         endcase
         #1 pins_chk("R7");
         rd_chk("R1", 2);
         if (op == 0) rd_chk("R5", 0);
         if (op == 5) rd_chk("R6", 4);
         if (op == 6 || op == 7) rd_chk("R7", 8 + $urandom_range(0, 7));
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule